// File: doc/BRIEF.md
# Encoded-Operation 32-bit ALU

This block is a purely combinational arithmetic and logic unit for a simple single-issue datapath. A 4-bit operation code selects one of thirteen functions applied to two 32-bit operands A and B, and a separate 5-bit amount drives the shifts of B. The block returns a 32-bit result word C and a single overflow flag V. Nothing is registered: the result settles within the same cycle that the operands and code are applied, so the surrounding pipeline decides where the value is captured.

The operation code is decoded into an internal operation kind. The decoder is a full case over all sixteen code values, and each value maps to exactly one kind: shift-left, add, subtract, logical or arithmetic shift-right, AND, OR, XOR, NOR, equal, not-equal, greater-than-zero and less-or-equal-zero. There are no sequential states or transitions. The shift-left, add and subtract kinds ignore the lowest code bit. Comparison kinds yield a word that holds 0 or 1 in bit 0. Only the add and subtract kinds can raise V.

Top module: `opsel_alu`

## Requirements
- R1: Codes 4'b0000 and 4'b0001 give C = B shifted left by Sa with zeros filled in, and V = 0.
- R2: Codes 4'b0010 and 4'b0011 give C = A + B modulo 2^32; V = 1 exactly when A and B have the same sign bit (bit 31) and C's sign bit differs from it.
- R3: Codes 4'b0110 and 4'b0111 give C = A - B modulo 2^32; V = 1 exactly when A and B have different sign bits and C's sign bit differs from A's.
- R4: Code 4'b0100 shifts B right by Sa with zero fill; code 4'b0101 shifts B right by Sa and fills with B's bit 31; both give V = 0.
- R5: Codes 4'b1000, 4'b1010, 4'b1100 and 4'b1110 give A AND B, A OR B, A XOR B and NOT(A OR B) respectively, with V = 0.
- R6: Code 4'b1011 gives 1 when A equals B, and code 4'b1001 gives 1 when they differ, else 0. The result sits in bit 0 with bits 31..1 zero.
- R7: Code 4'b1111 gives 1 when A, read as signed two's complement, is greater than zero. Code 4'b1101 gives 1 when A is zero or negative. Results are in bit 0 with bits 31..1 zero.
- R8: A shift amount of 0 returns B unchanged for codes 4'b0000, 4'b0100 and 4'b0101.
- R9: V is 0 for every code outside 4'b0010, 4'b0011, 4'b0110 and 4'b0111, even for operands that would overflow an add.
- R10: For the shift-left, add and subtract groups, bit 0 of the code has no effect: flipping it leaves C and V unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; the shifted value for shifts |
| sa_i | input | 5 | Shift amount |
| c_o | output | 32 | Result word |
| v_o | output | 1 | Signed overflow flag |

## Verification
The bench aims at the sign boundaries. These are the most positive and most negative values added to themselves or to one. They also include subtracting a negative from the largest positive. A design that took the carry-out as overflow, or used the add rule for subtract, would flag or miss these cases. Shifts by 31 and by 0 cover two faults: a right-arithmetic shift that fills with zeros, and a shifter stage that drops or repeats bits. The zero tests use 0, 1, the most negative and the most positive values, so an unsigned reading of A or an inverted boundary at zero shows up as a wrong bit 0. Flipping the low code bit catches a decoder that treats the don't-care bit as significant.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

    typedef enum logic [3:0] {
        K_SLL, K_ADD, K_SUB, K_SRL, K_SRA,
        K_AND, K_OR,  K_XOR, K_NOR,
        K_EQ,  K_NE,  K_GT,  K_LE
    } op_kind_e;

    // Full decode of the 4-bit operation code; low bit ignored for SLL/ADD/SUB (R10)
    function automatic op_kind_e decode_op(input logic [3:0] code);
        op_kind_e k;
        k = K_SLL;
        unique casez (code)
            4'b000?: k = K_SLL;
            4'b001?: k = K_ADD;
            4'b011?: k = K_SUB;
            4'b0100: k = K_SRL;
            4'b0101: k = K_SRA;
            4'b1000: k = K_AND;
            4'b1010: k = K_OR;
            4'b1100: k = K_XOR;
            4'b1110: k = K_NOR;
            4'b1011: k = K_EQ;
            4'b1001: k = K_NE;
            4'b1111: k = K_GT;
            4'b1101: k = K_LE;
            default: k = K_SLL;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/opsel_alu_shift.sv
module opsel_alu_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic             right_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] res_o
);
    logic             fill;
    logic [WIDTH-1:0] stage [SHW+1];

    assign fill     = arith_i & val_i[WIDTH-1];
    assign stage[0] = val_i;

    // Logarithmic barrel: stage i moves by 2**i when amount bit i is set
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 2 ** i;
        logic [WIDTH-1:0] moved;
        always_comb begin
            if (right_i) begin
                moved = {{STEP{fill}}, stage[i][WIDTH-1:STEP]};
            end else begin
                moved = {stage[i][WIDTH-1-STEP:0], {STEP{1'b0}}};
            end
        end
        assign stage[i+1] = amt_i[i] ? moved : stage[i];
    end

    assign res_o = stage[SHW];

endmodule

// File: rtl/opsel_alu_addsub.sv
module opsel_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;

    // Subtract as A + ~B + 1; overflow from the effective operand signs
    assign b_eff = sub_i ? ~b_i : b_i;
    assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
    assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/opsel_alu_logic.sv
module opsel_alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       fn_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (fn_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i | b_i;
            2'd2:    res_o = a_i ^ b_i;
            default: res_o = ~(a_i | b_i);
        endcase
    end

endmodule

// File: rtl/opsel_alu_cmp.sv
module opsel_alu_cmp #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       fn_i,
    output logic [WIDTH-1:0] res_o
);
    logic same;
    logic pos;
    logic bit0;

    assign same = (a_i == b_i);
    assign pos  = ~a_i[WIDTH-1] & (|a_i);

    // fn: 0 not-equal, 1 equal, 2 at-most-zero, 3 above-zero
    always_comb begin
        unique case (fn_i)
            2'd0:    bit0 = ~same;
            2'd1:    bit0 = same;
            2'd2:    bit0 = ~pos;
            default: bit0 = pos;
        endcase
    end

    assign res_o = {{(WIDTH-1){1'b0}}, bit0};

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
    import opsel_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [SHW-1:0]   sa_i,
    output logic [WIDTH-1:0] c_o,
    output logic             v_o
);
    localparam int MSB = WIDTH - 1;

    op_kind_e         kind;
    logic [WIDTH-1:0] shift_res;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] cmp_res;
    logic             arith_ovf;
    logic             is_right;
    logic             is_sub;

    assign kind     = decode_op(op_i);
    assign is_right = (kind == K_SRL) || (kind == K_SRA);
    assign is_sub   = (kind == K_SUB);

    opsel_alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .val_i   (b_i),
        .amt_i   (sa_i),
        .right_i (is_right),
        .arith_i (kind == K_SRA),
        .res_o   (shift_res)
    );

    opsel_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (is_sub),
        .sum_o (arith_res),
        .ovf_o (arith_ovf)
    );

    opsel_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .fn_i  (op_i[2:1]),
        .res_o (logic_res)
    );

    opsel_alu_cmp #(.WIDTH(WIDTH)) u_cmp (
        .a_i   (a_i),
        .b_i   (b_i),
        .fn_i  (op_i[2:1]),
        .res_o (cmp_res)
    );

    // Output selection by operation kind
    always_comb begin
        c_o = '0;
        v_o = 1'b0;
        unique case (kind)
            K_SLL, K_SRL, K_SRA:       c_o = shift_res;
            K_ADD, K_SUB: begin
                c_o = arith_res;
                v_o = arith_ovf;
            end
            K_AND, K_OR, K_XOR, K_NOR: c_o = logic_res;
            K_EQ, K_NE, K_GT, K_LE:    c_o = cmp_res;
            default:                   c_o = '0;
        endcase
    end

    // Port-level checks next to the output selection
    always_comb begin
        if (kind == K_ADD) begin
            p_add_ovf_r2: assert (v_o == ((a_i[MSB] == b_i[MSB]) && (c_o[MSB] != a_i[MSB])))
                else $error("add overflow flag wrong");
        end
        if (kind == K_SUB) begin
            p_sub_ovf_r3: assert (v_o == ((a_i[MSB] != b_i[MSB]) && (c_o[MSB] != a_i[MSB])))
                else $error("subtract overflow flag wrong");
        end
        if (kind == K_NOR) begin
            p_nor_r5: assert ((c_o | a_i | b_i) == {WIDTH{1'b1}} && (c_o & (a_i | b_i)) == '0)
                else $error("nor result wrong");
        end
        if (kind == K_EQ || kind == K_NE) begin
            p_cmp_upper_zero_r6: assert (c_o[WIDTH-1:1] == '0)
                else $error("equality result has upper bits set");
        end
        if (kind == K_GT || kind == K_LE) begin
            p_zero_test_r7: assert (c_o[WIDTH-1:1] == '0 &&
                                    c_o[0] == ((kind == K_GT) ? ($signed(a_i) > 0) : ($signed(a_i) <= 0)))
                else $error("zero test wrong");
        end
        if ((kind == K_SLL || is_right) && sa_i == '0) begin
            p_shift_zero_r8: assert (c_o == b_i)
                else $error("zero shift altered B");
        end
        if (kind != K_ADD && kind != K_SUB) begin
            p_no_overflow_r9: assert (v_o == 1'b0)
                else $error("overflow outside add/sub");
        end
    end

endmodule

// File: tb/opsel_alu_bench.sv
module opsel_alu_bench;

    localparam int W  = 32;
    localparam int NV = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op;
    logic [W-1:0]  a, b;
    logic [4:0]    sa;
    logic [W-1:0]  c;
    logic          v;

    int applied = 0;
    int bad     = 0;

    always #5 clk = ~clk;

    opsel_alu u_opsel_alu (
        .op_i (op), .a_i (a), .b_i (b), .sa_i (sa), .c_o (c), .v_o (v)
    );

    // {req, op, a, b, sa, c_expected, v_expected}
    localparam logic [109:0] VEC [NV] = '{
        {4'd1, 4'b0000, 32'h0000_0000, 32'h0000_0001, 5'd31, 32'h8000_0000, 1'b0}, // R1
        {4'd1, 4'b0001, 32'h0000_0000, 32'h1234_5678, 5'd4,  32'h2345_6780, 1'b0}, // R1
        {4'd2, 4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0,  32'h8000_0000, 1'b1}, // R2
        {4'd2, 4'b0011, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0,  32'h0000_0000, 1'b0}, // R2
        {4'd2, 4'b0010, 32'h8000_0000, 32'h8000_0000, 5'd0,  32'h0000_0000, 1'b1}, // R2
        {4'd3, 4'b0110, 32'h8000_0000, 32'h0000_0001, 5'd0,  32'h7FFF_FFFF, 1'b1}, // R3
        {4'd3, 4'b0111, 32'h0000_0005, 32'h0000_0007, 5'd0,  32'hFFFF_FFFE, 1'b0}, // R3
        {4'd3, 4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0,  32'h8000_0000, 1'b1}, // R3
        {4'd4, 4'b0100, 32'h0000_0000, 32'h8000_0000, 5'd31, 32'h0000_0001, 1'b0}, // R4
        {4'd4, 4'b0101, 32'h0000_0000, 32'h8000_0000, 5'd31, 32'hFFFF_FFFF, 1'b0}, // R4
        {4'd4, 4'b0101, 32'h0000_0000, 32'h4000_0000, 5'd30, 32'h0000_0001, 1'b0}, // R4
        {4'd5, 4'b1000, 32'hF0F0_F0F0, 32'hFF00_FF00, 5'd0,  32'hF000_F000, 1'b0}, // R5
        {4'd5, 4'b1010, 32'hF0F0_F0F0, 32'hFF00_FF00, 5'd0,  32'hFFF0_FFF0, 1'b0}, // R5
        {4'd5, 4'b1100, 32'hF0F0_F0F0, 32'hFF00_FF00, 5'd0,  32'h0FF0_0FF0, 1'b0}, // R5
        {4'd5, 4'b1110, 32'hF0F0_F0F0, 32'hFF00_FF00, 5'd0,  32'h000F_000F, 1'b0}, // R5
        {4'd6, 4'b1011, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0,  32'h0000_0001, 1'b0}, // R6
        {4'd6, 4'b1001, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'd0,  32'h0000_0000, 1'b0}, // R6
        {4'd6, 4'b1011, 32'h0000_0001, 32'h8000_0001, 5'd0,  32'h0000_0000, 1'b0}, // R6
        {4'd7, 4'b1111, 32'h8000_0000, 32'h0000_0000, 5'd0,  32'h0000_0000, 1'b0}, // R7
        {4'd7, 4'b1111, 32'h0000_0001, 32'h0000_0000, 5'd0,  32'h0000_0001, 1'b0}, // R7
        {4'd7, 4'b1101, 32'h0000_0000, 32'h0000_0000, 5'd0,  32'h0000_0001, 1'b0}, // R7
        {4'd7, 4'b1101, 32'h7FFF_FFFF, 32'h0000_0000, 5'd0,  32'h0000_0000, 1'b0}, // R7
        {4'd8, 4'b0000, 32'h0000_0000, 32'hA5A5_A5A5, 5'd0,  32'hA5A5_A5A5, 1'b0}  // R8
    };

    // Independent reference from the requirement text
    function automatic logic [W:0] model(input logic [3:0] o, input logic [W-1:0] x,
                                         input logic [W-1:0] y, input logic [4:0] s);
        logic [W-1:0] r;
        logic         f;
        r = '0;
        f = 1'b0;
        case (o)
            4'b0000, 4'b0001: r = y << s;
            4'b0010, 4'b0011: begin
                r = x + y;
                f = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
            end
            4'b0110, 4'b0111: begin
                r = x - y;
                f = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
            end
            4'b0100: r = y >> s;
            4'b0101: r = $unsigned($signed(y) >>> s);
            4'b1000: r = x & y;
            4'b1010: r = x | y;
            4'b1100: r = x ^ y;
            4'b1110: r = ~(x | y);
            4'b1011: r = {31'd0, x == y};
            4'b1001: r = {31'd0, x != y};
            4'b1111: r = {31'd0, $signed(x) > 0};
            4'b1101: r = {31'd0, $signed(x) <= 0};
            default: r = '0;
        endcase
        return {f, r};
    endfunction

    task automatic apply(input logic [3:0] o, input logic [W-1:0] x,
                         input logic [W-1:0] y, input logic [4:0] s);
        @(posedge clk);
        op = o; a = x; b = y; sa = s;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] ec, input logic ev);
        applied++;
        if (c !== ec || v !== ev) begin
            bad++;
            $display("FAIL %s op=%b a=%h b=%h sa=%0d: actual c=%h v=%b expected c=%h v=%b",
                     req, op, a, b, sa, c, v, ec, ev);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog all-reqs: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] lf;
        logic [W:0]   e0, e1;
        op = 4'b0000; a = '0; b = '0; sa = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", '0, 1'b0); // all-zero inputs give zero, no overflow

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][105:102], VEC[i][101:70], VEC[i][69:38], VEC[i][37:33]);
            check($sformatf("R%0d table[%0d]", VEC[i][109:106], i), VEC[i][32:1], VEC[i][0]);
        end

        // R8: zero shift on right shifts
        apply(4'b0100, '0, 32'h8000_00F1, 5'd0); check("R8 srl0", 32'h8000_00F1, 1'b0);
        apply(4'b0101, '0, 32'h8000_00F1, 5'd0); check("R8 sra0", 32'h8000_00F1, 1'b0);

        // R9: operands that overflow an add give V=0 on every other code
        for (int k = 0; k < 16; k++) begin
            if (k[3:1] != 3'b001 && k[3:1] != 3'b011) begin
                apply(k[3:0], 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd1);
                applied++;
                if (v !== 1'b0) begin
                    bad++;
                    $display("FAIL R9 op=%b: actual v=%b expected v=0", k[3:0], v);
                end
            end
        end

        // R6/R7 boundary: most negative vs zero tests, equal-but-for-sign
        apply(4'b1101, 32'h8000_0000, '0, 5'd0); check("R7 le minneg", 32'd1, 1'b0);
        apply(4'b1111, 32'h7FFF_FFFF, '0, 5'd0); check("R7 gt maxpos", 32'd1, 1'b0);
        apply(4'b1111, 32'h0000_0000, '0, 5'd0); check("R7 gt zero", 32'd0, 1'b0);
        apply(4'b1001, 32'h0000_0001, 32'h8000_0001, 5'd0); check("R6 ne", 32'd1, 1'b0);

        // Pseudo-random sweep over all codes; R10 flip of low code bit
        lf = 32'hACE1_1234;
        for (int n = 0; n < 600; n++) begin
            logic [3:0]   o;
            logic [W-1:0] x, y;
            logic [4:0]   s;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            x  = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            y  = (n % 7 == 0) ? x : {lf[15:0], lf[31:16]};
            o  = n[3:0];
            s  = lf[8:4];
            e0 = model(o, x, y, s);
            apply(o, x, y, s);
            check("R1-group sweep model R2 R3 R4 R5", e0[W-1:0], e0[W]);
            if (o[3] == 1'b0 && o[2:1] != 2'b10) begin
                e1 = e0;
                apply(o ^ 4'b0001, x, y, s);
                check("R10 low-bit don't-care", e1[W-1:0], e1[W]);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule